// File: doc/BRIEF.md
# Phase-Disposition Multilevel PWM Gate Generator

This block turns a signed digital reference sample into gate commands for a fifteen-step single-phase inverter. The inverter stage has three series cells whose DC sources are weighted 1, 2 and 4 units, so the cells together reach plus or minus 7 units. A four-switch polarity bridge follows the cells and sets the sign of the output. The block compares the reference against fourteen triangular carriers. All fourteen carriers share one phase and one amplitude and differ only in their vertical offset. The number of carriers that the reference exceeds gives an output step between -7 and +7.

One up/down counter with a prescaler produces the shared triangle. Each carrier is that triangle plus a fixed multiple of the carrier amplitude. The comparison result is captured only at the triangle's valley and peak. Between these turning points the step and all gate bits stay unchanged. The captured step is decoded straight into binary-weighted cell switch pairs and a polarity leg selection. Dead-time insertion and fault handling are left to the stage that follows.

Top module: `pdpwm_modulator`

## Requirements
- R1: While reset is high, and on the first clock after it, the step output is 0 and all six cell gate bits and both leg bits are 0.
- R2: The triangle rises from 0 to AMP and falls back to 0 in steps of one, one step per prescaler tick. The outputs change only on the edge where the triangle sits at 0 (valley) or at AMP (peak), and hold their value on every other edge.
- R3: On a valley or peak edge the captured step is the count of carriers k = 0..13 with reference > ramp + k*AMP - 7*AMP, minus 7. The comparison is strict and uses the reference present at that edge.
- R4: A reference above 7*AMP gives step +7 at both turning points. A reference at or below -7*AMP gives step -7 at both.
- R5: cell_hi_o is the magnitude of the step in binary, with bit 0 driving the 1-unit cell, bit 1 the 2-unit cell and bit 2 the 4-unit cell.
- R6: For a nonzero step, each cell_lo_o bit is the inverse of the matching cell_hi_o bit. No cell ever has both of its bits set.
- R7: At step 0, all six cell bits and both leg bits are 0.
- R8: leg_pos_o is 1 exactly when the step is positive and leg_neg_o is 1 exactly when the step is negative. The two are never 1 together.
- R9: With enable low, the next edge clears the step and all gate bits and restarts the triangle at the valley. The first edge that sees enable high is a valley capture.
- R10: The triangle advances on the first enabled edge and then once every div_i+1 clocks. A half period therefore lasts AMP*(div_i+1) clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Run enable; low clears outputs and restarts the triangle |
| ref_i | input | REF_W (9) | Signed reference sample, two's complement |
| div_i | input | DIV_W (8) | Prescaler setting; the ramp steps every div_i+1 clocks |
| cell_hi_o | output | 3 | Positive switch of each cell, bit 0 = 1-unit cell |
| cell_lo_o | output | 3 | Complementary switch of each cell |
| leg_pos_o | output | 1 | Polarity bridge drives the positive leg |
| leg_neg_o | output | 1 | Polarity bridge drives the negative leg |
| level_o | output | 4 | Signed output step, -7 to +7 |

## Verification
A reference change can land on the same edge as a turning-point capture. The bench provokes this by moving the reference on the falling edge just before the peak edge and checking that the peak capture reflects the new value. It then moves the reference again one edge after the peak and checks that the step holds at the peak result until the next valley takes up the third value. Saturation and a capture also coincide at every turning point when the reference lies outside the stack. The bench judges these cases by requiring ±7 at both the valley and the peak.

// File: rtl/pdpwm_pkg.sv
package pdpwm_pkg;

    // Cell count and the derived step range / carrier count
    localparam int CELLS = 3;
    localparam int MAG   = (1 << CELLS) - 1;
    localparam int NCAR  = 2 * MAG;
    localparam int LVL_W = CELLS + 1;
    localparam int CNT_W = $clog2(NCAR + 1);

    typedef logic signed [LVL_W-1:0] level_t;

    typedef struct packed {
        logic [CELLS-1:0] hi;
        logic [CELLS-1:0] lo;
        logic             leg_pos;
        logic             leg_neg;
    } gate_t;

    // Step -> cell pairs and polarity legs
    function automatic gate_t decode_level(input level_t lv);
        gate_t            g;
        logic [LVL_W-1:0] mag;
        mag       = lv[LVL_W-1] ? LVL_W'(-lv) : LVL_W'(lv);
        g.hi      = mag[CELLS-1:0];
        g.lo      = (lv == '0) ? '0 : ~mag[CELLS-1:0];
        g.leg_pos = (lv > 0);
        g.leg_neg = lv[LVL_W-1];
        return g;
    endfunction

endpackage

// File: rtl/pdpwm_triangle.sv
module pdpwm_triangle #(
    parameter int AMP   = 16,
    parameter int DIV_W = 8,
    localparam int TW   = $clog2(AMP + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [DIV_W-1:0] div_i,
    output logic [TW-1:0]    ramp_o,
    output logic             turn_o
);

    logic [DIV_W-1:0] pre_q;
    logic [TW-1:0]    ramp_q;
    logic             up_q;
    logic             tick;

    assign tick   = (pre_q == '0);
    assign turn_o = en && tick && (ramp_q == '0 || ramp_q == TW'(AMP));
    assign ramp_o = ramp_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            pre_q  <= '0;
            ramp_q <= '0;
            up_q   <= 1'b1;
        end else begin
            pre_q <= tick ? div_i : pre_q - 1'b1;
            if (tick) begin
                if (ramp_q == TW'(AMP)) begin
                    up_q   <= 1'b0;
                    ramp_q <= TW'(AMP - 1);
                end else if (ramp_q == '0) begin
                    up_q   <= 1'b1;
                    ramp_q <= TW'(1);
                end else begin
                    ramp_q <= up_q ? ramp_q + 1'b1 : ramp_q - 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/pdpwm_stack.sv
module pdpwm_stack
    import pdpwm_pkg::*;
#(
    parameter int AMP   = 16,
    parameter int REF_W = 9,
    localparam int TW   = $clog2(AMP + 1),
    localparam int SPAN = $clog2(MAG * AMP + AMP + 1) + 2,
    localparam int CW   = ((REF_W > SPAN) ? REF_W : SPAN) + 1
) (
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [TW-1:0]           ramp_i,
    output level_t                  level_o
);

    logic signed [CW-1:0] ref_x;
    logic signed [CW-1:0] ramp_x;
    logic [NCAR-1:0]      hit;
    logic [CNT_W-1:0]     cnt;
    logic signed [CNT_W:0] lv_wide;

    assign ref_x  = CW'(ref_i);
    assign ramp_x = signed'({{(CW-TW){1'b0}}, ramp_i});

    // One comparator per carrier; carrier k sits k*AMP above the bottom
    for (genvar k = 0; k < NCAR; k++) begin : g_car
        localparam int OFS = k * AMP - MAG * AMP;
        logic signed [CW-1:0] carrier;
        assign carrier = ramp_x + CW'(OFS);
        assign hit[k]  = (ref_x > carrier);
    end

    always_comb begin
        cnt = '0;
        for (int k = 0; k < NCAR; k++) begin
            cnt = cnt + CNT_W'(hit[k]);
        end
    end

    assign lv_wide = signed'({1'b0, cnt}) - (CNT_W+1)'(MAG);
    assign level_o = level_t'(lv_wide);

endmodule

// File: rtl/pdpwm_gate_reg.sv
module pdpwm_gate_reg
    import pdpwm_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   turn_i,
    input  level_t level_i,
    output level_t level_o,
    output gate_t  gate_o
);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            level_o <= '0;
            gate_o  <= '0;
        end else if (turn_i) begin
            level_o <= level_i;
            gate_o  <= decode_level(level_i);
        end
    end

endmodule

// File: rtl/pdpwm_modulator.sv
module pdpwm_modulator
    import pdpwm_pkg::*;
#(
    parameter int AMP   = 16,
    parameter int REF_W = 9,
    parameter int DIV_W = 8,
    localparam int TW   = $clog2(AMP + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic signed [REF_W-1:0] ref_i,
    input  logic [DIV_W-1:0]        div_i,
    output logic [CELLS-1:0]        cell_hi_o,
    output logic [CELLS-1:0]        cell_lo_o,
    output logic                    leg_pos_o,
    output logic                    leg_neg_o,
    output logic signed [LVL_W-1:0] level_o
);

    logic [TW-1:0] ramp;
    logic          ramp_turn;
    level_t        level_cmp;
    level_t        level_q;
    gate_t         gate_q;

    pdpwm_triangle #(.AMP(AMP), .DIV_W(DIV_W)) u_tri (
        .clk    (clk),
        .rst    (rst),
        .en     (en),
        .div_i  (div_i),
        .ramp_o (ramp),
        .turn_o (ramp_turn)
    );

    pdpwm_stack #(.AMP(AMP), .REF_W(REF_W)) u_stack (
        .ref_i   (ref_i),
        .ramp_i  (ramp),
        .level_o (level_cmp)
    );

    pdpwm_gate_reg u_gate (
        .clk     (clk),
        .rst     (rst),
        .en      (en),
        .turn_i  (ramp_turn),
        .level_i (level_cmp),
        .level_o (level_q),
        .gate_o  (gate_q)
    );

    assign cell_hi_o = gate_q.hi;
    assign cell_lo_o = gate_q.lo;
    assign leg_pos_o = gate_q.leg_pos;
    assign leg_neg_o = gate_q.leg_neg;
    assign level_o   = level_q;

endmodule

// File: rtl/pdpwm_checker.sv
module pdpwm_checker (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              turn,
    input logic [2:0]        cell_hi,
    input logic [2:0]        cell_lo,
    input logic              leg_pos,
    input logic              leg_neg,
    input logic signed [3:0] level
);

    assert_cell_exclusive_R6: assert property (@(posedge clk) disable iff (rst)
        (cell_hi & cell_lo) == 3'b000);

    assert_leg_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        !(leg_pos && leg_neg));

    assert_leg_matches_sign_R8: assert property (@(posedge clk) disable iff (rst)
        (leg_pos == (level > 0)) && (leg_neg == (level < 0)));

    assert_zero_all_off_R7: assert property (@(posedge clk) disable iff (rst)
        (level == 4'sd0) |-> (cell_hi == 3'b000 && cell_lo == 3'b000 && !leg_pos && !leg_neg));

    assert_hold_between_turns_R2: assert property (@(posedge clk) disable iff (rst)
        (en && !turn) |=> $stable(level));

    assert_disable_clears_R9: assert property (@(posedge clk) disable iff (rst)
        !en |=> (level == 4'sd0 && cell_hi == 3'b000 && cell_lo == 3'b000 && !leg_pos && !leg_neg));

endmodule

bind pdpwm_modulator pdpwm_checker u_chk (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .turn    (ramp_turn),
    .cell_hi (cell_hi_o),
    .cell_lo (cell_lo_o),
    .leg_pos (leg_pos_o),
    .leg_neg (leg_neg_o),
    .level   (level_o)
);

// File: tb/tb_pdpwm_modulator.sv
`timescale 1ns/1ps
module tb_pdpwm_modulator;

    localparam int AMP = 16;
    localparam int MAG = 7;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              en  = 1'b0;
    logic signed [8:0] ref_s = '0;
    logic [7:0]        div_s = '0;
    logic [2:0]        cell_hi, cell_lo;
    logic              leg_pos, leg_neg;
    logic signed [3:0] level;

    int checks   = 0;
    int failures = 0;

    always #2 clk = ~clk;

    pdpwm_modulator dut (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .ref_i     (ref_s),
        .div_i     (div_s),
        .cell_hi_o (cell_hi),
        .cell_lo_o (cell_lo),
        .leg_pos_o (leg_pos),
        .leg_neg_o (leg_neg),
        .level_o   (level)
    );

    // Step expected from the carrier stack rule at a given ramp value
    function automatic int exp_level(input int r, input int ramp);
        int c = 0;
        for (int k = 0; k < 2*MAG; k++) begin
            if (r > ramp + k*AMP - MAG*AMP) c++;
        end
        return c - MAG;
    endfunction

    task automatic check_out(input int exp, input string tag);
        int          mag;
        logic [2:0]  e_hi, e_lo;
        logic        e_lp, e_ln;
        mag  = (exp < 0) ? -exp : exp;
        e_hi = 3'(mag);
        e_lo = (exp == 0) ? 3'b000 : ~3'(mag);
        e_lp = (exp > 0);
        e_ln = (exp < 0);
        checks++;
        if (int'(level) != exp) begin
            failures++;
            $display("FAIL %s level: got %0d expected %0d", tag, int'(level), exp);
        end
        checks++;
        if (cell_hi !== e_hi || cell_lo !== e_lo || leg_pos !== e_lp || leg_neg !== e_ln) begin
            failures++;
            $display("FAIL %s gates (R5 R6 R7 R8): got hi=%b lo=%b lp=%b ln=%b expected hi=%b lo=%b lp=%b ln=%b",
                     tag, cell_hi, cell_lo, leg_pos, leg_neg, e_hi, e_lo, e_lp, e_ln);
        end
    endtask

    // Drop enable for one edge (R9), then raise it; returns after the valley capture edge
    task automatic restart(input int r, input int d, input string tag);
        @(negedge clk);
        ref_s = 9'(r);
        div_s = 8'(d);
        en    = 1'b0;
        @(negedge clk);
        check_out(0, "R9 disable clears");
        en = 1'b1;
        @(negedge clk);
        check_out(exp_level(r, 0), tag);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_out(0, "R1 in reset");
        rst = 1'b0;
        @(negedge clk);
        check_out(0, "R1 after reset");
    endtask

    // Full period at constant reference: valley, hold, peak, hold, valley
    task automatic t_period(input int r, input int d, input string tag);
        int h = AMP * (d + 1);
        restart(r, d, {tag, " R3 valley"});
        for (int j = 1; j < h; j++) begin
            @(negedge clk);
            check_out(exp_level(r, 0), {tag, " R2 hold low"});
        end
        @(negedge clk);
        check_out(exp_level(r, AMP), {tag, " R3 peak R10"});
        for (int j = 1; j < h; j++) begin
            @(negedge clk);
            check_out(exp_level(r, AMP), {tag, " R2 hold high"});
        end
        @(negedge clk);
        check_out(exp_level(r, 0), {tag, " R2 next valley"});
    endtask

    // Reference moved right before the peak edge, then again right after it
    task automatic t_ref_on_turn();
        int h = AMP;
        restart(20, 0, "R3 ref-turn valley");
        for (int j = 1; j < h; j++) begin
            @(negedge clk);
            check_out(exp_level(20, 0), "R2 ref-turn hold");
        end
        ref_s = -9'sd30;
        @(negedge clk);
        check_out(exp_level(-30, AMP), "R3 new ref at peak");
        ref_s = 9'sd90;
        for (int j = 1; j < h; j++) begin
            @(negedge clk);
            check_out(exp_level(-30, AMP), "R2 ref change ignored until valley");
        end
        @(negedge clk);
        check_out(exp_level(90, 0), "R3 valley takes later ref");
    endtask

    // Enable dropped in the middle of a half period
    task automatic t_enable_mid();
        restart(-70, 0, "R3 pre-drop valley");
        repeat (5) @(negedge clk);
        en = 1'b0;
        @(negedge clk);
        check_out(0, "R9 mid-run drop");
        en = 1'b1;
        @(negedge clk);
        check_out(exp_level(-70, 0), "R9 restart is valley");
    endtask

    initial begin
        #(200000 * 4);
        failures++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_period(20, 0, "mid positive");
        t_period(-50, 0, "mid negative");
        t_period(0, 0, "R7 zero ref");
        t_period(112, 0, "top edge");
        t_period(113, 0, "R4 just above");
        t_period(200, 0, "R4 high sat");
        t_period(-112, 0, "R4 bottom edge");
        t_period(-256, 0, "R4 low sat");
        t_period(40, 2, "R10 div2");
        t_period(-5, 1, "R10 div1");
        t_ref_on_turn();
        t_enable_mid();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule